// File: doc/BRIEF.md
# Capture-Mode Timer Channel

This block is a single 16-bit timer channel used to timestamp activity on an input pin. A free-running counter is enabled and disabled by one-cycle commands and restarted from zero by a trigger. The trigger can be a software pulse, a chosen edge on either input pin, or the counter reaching a compare value. Edges on pin A copy the current count into two capture registers, first into capture A and then into capture B. A pair of captures therefore gives a pulse width or a period without any software timing.

Each capture marks its register as unread until the matching read strobe arrives. A capture that lands on an unread value is reported as an overrun. Events set sticky status flags, which one read strobe clears. An interrupt mask chooses which flags drive the interrupt line. Optionally, a capture into B can freeze the counter or also drop the clock-enabled state. This is useful for one-shot measurements.

Top module: `capture_timer`

## Requirements
- R1: After reset the count, both capture registers, the status flags, the interrupt mask, `clk_on` and `irq` are all zero.
- R2: A trigger (a `cmd_swtrig` pulse or any other trigger source) clears the count to 0 on the next edge. While the channel runs, the count rises by one on every clock edge after that.
- R3: `cmd_start` sets `clk_on` and `cmd_stop` clears it; if both are high, stop wins. While `clk_on` is 0 the count holds its value, and counting resumes from that value once started again.
- R4: With `mode[7]` set, a running count equal to `rc_val` restarts the count from 0 on the next edge. Every such match sets status bit 4. With `mode[7]` clear, the count runs past `rc_val`.
- R5: A running count at 0xFFFF wraps to 0 on the next edge and sets status bit 0.
- R6: Pins pass through a two-flop synchronizer. A level change on `pin_a` applied before edge k is captured at edge k+2, and the captured value is the count held just before that edge. Edge codes are 00 none, 01 rising, 10 falling and 11 both. The code in `mode[1:0]` selects the edges that load capture A, and the code in `mode[3:2]` selects the edges that load capture B.
- R7: Capture A loads only when B has been loaded since the last A load, or when A has never been loaded. Capture B loads only after a load of A that B has not yet followed. An edge that matches the wrong register in the sequence is ignored.
- R8: Loading a capture register whose previous value has not been acknowledged with `rd_a` or `rd_b` sets status bit 1. A load that follows an acknowledgement does not set it.
- R9: Status bit 5 is set on a load of capture A, bit 6 on a load of capture B and bit 7 on an external trigger. Bits 2 and 3 stay 0. A `rd_status` pulse clears all the flags.
- R10: `mode[5:4]` holds the edge code for the external trigger, and `mode[6]` selects its pin: 0 for pin A, 1 for pin B. A matching edge restarts the count on the same edge that R6 gives for a capture. Edges on the unselected pin, or edges that do not match the code, leave the count alone.
- R11: With `mode[8]` set, a load of capture B freezes the count at the captured value until the next trigger. `mode[9]` does the same and also clears `clk_on`.
- R12: `irq_set` bits set mask bits and `irq_clr` bits clear them; if both are high, clear wins. `irq` is high when some status flag and its mask bit are both set. Masking does not change the status flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Enable-clock command pulse |
| cmd_stop | input | 1 | Disable-clock command pulse |
| cmd_swtrig | input | 1 | Software trigger pulse |
| pin_a | input | 1 | Capture (and optional trigger) input, asynchronous |
| pin_b | input | 1 | Optional trigger input, asynchronous |
| mode | input | 10 | Channel configuration (fields in R6, R4, R10, R11) |
| rc_val | input | 16 | Compare value for restart |
| rd_a | input | 1 | Acknowledge read of capture A |
| rd_b | input | 1 | Acknowledge read of capture B |
| rd_status | input | 1 | Read-and-clear status strobe |
| irq_set | input | 8 | Mask bits to enable |
| irq_clr | input | 8 | Mask bits to disable |
| count | output | 16 | Counter value |
| cap_a | output | 16 | Capture register A |
| cap_b | output | 16 | Capture register B |
| status | output | 8 | Sticky event flags |
| irq_mask | output | 8 | Interrupt mask |
| clk_on | output | 1 | Clock-enabled state |
| irq | output | 1 | Interrupt request |

## Verification
Commands and the software trigger take effect on the first edge after they are driven. Pin events reach the captures, the trigger and their flags on the third edge after the pin changes, and `irq` follows the flags with no added delay. The driver records the cycle of each stimulus and queues every expected value with the cycle number in which it becomes due. The monitor compares values only in that cycle, half a period after the edge. Captured values are derived from the cycle distance to the last restart.

// File: rtl/capture_timer.sv
module capture_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_start,
  input  logic         cmd_stop,
  input  logic         cmd_swtrig,
  input  logic         pin_a,
  input  logic         pin_b,
  input  logic [9:0]   mode,
  input  logic [W-1:0] rc_val,
  input  logic         rd_a,
  input  logic         rd_b,
  input  logic         rd_status,
  input  logic [7:0]   irq_set,
  input  logic [7:0]   irq_clr,
  output logic [W-1:0] count,
  output logic [W-1:0] cap_a,
  output logic [W-1:0] cap_b,
  output logic [7:0]   status,
  output logic [7:0]   irq_mask,
  output logic         clk_on,
  output logic         irq
);
  localparam logic [W-1:0] TOP = '1;

  function automatic logic edge_hit(input logic [1:0] code, input logic rise, input logic fall);
    return (code[0] & rise) | (code[1] & fall);
  endfunction

  logic [2:0] sa, sb;
  logic held, want_b, a_unread, b_unread;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sa <= '0;
      sb <= '0;
    end else begin
      sa <= {sa[1:0], pin_a};
      sb <= {sb[1:0], pin_b};
    end

  wire rise_a = sa[1] & ~sa[2];
  wire fall_a = ~sa[1] & sa[2];
  wire rise_b = sb[1] & ~sb[2];
  wire fall_b = ~sb[1] & sb[2];

  wire run     = clk_on & ~held;
  wire rc_hit  = run & (count == rc_val);
  wire ext_hit = mode[6] ? edge_hit(mode[5:4], rise_b, fall_b)
                         : edge_hit(mode[5:4], rise_a, fall_a);
  wire trig    = cmd_swtrig | ext_hit | (rc_hit & mode[7]);
  wire ld_a    = edge_hit(mode[1:0], rise_a, fall_a) & ~want_b;
  wire ld_b    = edge_hit(mode[3:2], rise_a, fall_a) & want_b;
  wire stop_b  = ld_b & (mode[8] | mode[9]);
  wire ovf     = run & ~trig & ~stop_b & (count == TOP);
  wire lov     = (ld_a & a_unread & ~rd_a) | (ld_b & b_unread & ~rd_b);
  wire [7:0] flag_set = {ext_hit, ld_b, ld_a, rc_hit, 2'b00, lov, ovf};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      count    <= '0;
      held     <= 1'b0;
      clk_on   <= 1'b0;
      cap_a    <= '0;
      cap_b    <= '0;
      want_b   <= 1'b0;
      a_unread <= 1'b0;
      b_unread <= 1'b0;
      status   <= '0;
      irq_mask <= '0;
    end else begin
      if (trig)
        count <= '0;
      else if (run && !stop_b)
        count <= count + 1'b1;

      if (stop_b)
        held <= 1'b1;
      else if (trig)
        held <= 1'b0;

      if (cmd_stop || (ld_b && mode[9]))
        clk_on <= 1'b0;
      else if (cmd_start)
        clk_on <= 1'b1;

      if (ld_a) cap_a <= count;
      if (ld_b) cap_b <= count;

      if (ld_a)
        want_b <= 1'b1;
      else if (ld_b)
        want_b <= 1'b0;

      if (ld_a)
        a_unread <= 1'b1;
      else if (rd_a)
        a_unread <= 1'b0;

      if (ld_b)
        b_unread <= 1'b1;
      else if (rd_b)
        b_unread <= 1'b0;

      status   <= (rd_status ? 8'h00 : status) | flag_set;
      irq_mask <= (irq_mask | irq_set) & ~irq_clr;
    end

  assign irq = |(status & irq_mask);

  assert_stop_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |=> !clk_on);

  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (count == '0) && status[0]);

  assert_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_a && a_unread && !rd_a) |=> status[1]);

  assert_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !trig) |=> $stable(count));

  assert_off_on_b_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_b && mode[9]) |=> !clk_on);

  assert_quiet_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 8'h00) |-> !irq);

  assert_rc_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rc_hit && mode[7] && !stop_b) |=> (count == '0) && status[4]);
endmodule

// File: tb/test_capture_timer.sv
module test_capture_timer;
  localparam int CLK_PERIOD = 10;
  localparam int S_CNT = 0, S_A = 1, S_B = 2, S_ST = 3, S_ON = 4, S_IRQ = 5, S_MSK = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_start = 0, cmd_stop = 0, cmd_swtrig = 0, pin_a = 0, pin_b = 0;
  logic [9:0] mode = '0;
  logic [15:0] rc_val = 16'h8000;
  logic rd_a = 0, rd_b = 0, rd_status = 0;
  logic [7:0] irq_set = '0, irq_clr = '0;
  logic [15:0] count, cap_a, cap_b;
  logic [7:0] status, irq_mask;
  logic clk_on, irq;

  capture_timer i_capture_timer (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_swtrig(cmd_swtrig), .pin_a(pin_a), .pin_b(pin_b), .mode(mode),
    .rc_val(rc_val), .rd_a(rd_a), .rd_b(rd_b), .rd_status(rd_status),
    .irq_set(irq_set), .irq_clr(irq_clr), .count(count), .cap_a(cap_a),
    .cap_b(cap_b), .status(status), .irq_mask(irq_mask), .clk_on(clk_on), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0, pcyc = 0, n_cmp = 0, n_bad = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int due; int sel; logic [15:0] exp; string tag; } item_t;
  item_t sbq[$];

  function automatic logic [15:0] pick(int s);
    case (s)
      S_CNT: return count;
      S_A:   return cap_a;
      S_B:   return cap_b;
      S_ST:  return {8'h00, status};
      S_ON:  return {15'h0, clk_on};
      S_IRQ: return {15'h0, irq};
      default: return {8'h00, irq_mask};
    endcase
  endfunction

  always @(negedge clk) begin
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].due <= cyc) begin
        n_cmp++;
        if (sbq[i].due != cyc || pick(sbq[i].sel) !== sbq[i].exp) begin
          n_bad++;
          $display("FAIL %s sel=%0d at cycle %0d: actual %h expected %h",
                   sbq[i].tag, sbq[i].sel, cyc, pick(sbq[i].sel), sbq[i].exp);
        end
        sbq.delete(i);
      end
    end
  end

  task automatic ticks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic exp_in(int n, int sel, logic [15:0] v, string tag);
    item_t it;
    it.due = cyc + n; it.sel = sel; it.exp = v; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic reset_dut(logic [9:0] m, logic [15:0] rc);
    rst_n = 0; mode = m; rc_val = rc; pin_a = 0; pin_b = 0;
    cmd_start = 0; cmd_stop = 0; cmd_swtrig = 0;
    rd_a = 0; rd_b = 0; rd_status = 0; irq_set = 0; irq_clr = 0;
    ticks(2);
    rst_n = 1;
    ticks(1);
  endtask

  task automatic go();
    cmd_start = 1; cmd_swtrig = 1;
    ticks(1);
    cmd_start = 0; cmd_swtrig = 0;
    pcyc = cyc;
  endtask

  function automatic logic [15:0] capv(int ahead);
    return 16'(cyc + ahead - pcyc);
  endfunction

  initial begin
    logic [15:0] v;
    ticks(1);
    // R1 reset state
    reset_dut(10'h000, 16'h8000);
    exp_in(1, S_CNT, 0, "R1"); exp_in(1, S_A, 0, "R1"); exp_in(1, S_B, 0, "R1");
    exp_in(1, S_ST, 0, "R1"); exp_in(1, S_ON, 0, "R1"); exp_in(1, S_IRQ, 0, "R1");
    exp_in(1, S_MSK, 0, "R1");
    ticks(1);

    // R2 counting from a trigger, R3 stop/start
    go();
    exp_in(5, S_CNT, 5, "R2"); exp_in(5, S_ON, 1, "R3");
    ticks(5);
    cmd_stop = 1; ticks(1); cmd_stop = 0;
    exp_in(3, S_CNT, 6, "R3"); exp_in(3, S_ON, 0, "R3");
    ticks(3);
    cmd_start = 1; ticks(1); cmd_start = 0;
    exp_in(4, S_CNT, 10, "R3");
    ticks(4);
    cmd_swtrig = 1; ticks(1); cmd_swtrig = 0;
    exp_in(2, S_CNT, 2, "R2");
    ticks(2);

    // R4 compare restart
    reset_dut(10'h080, 16'd4);
    go();
    exp_in(4, S_CNT, 4, "R4"); exp_in(5, S_CNT, 0, "R4");
    exp_in(7, S_CNT, 2, "R4"); exp_in(7, S_ST, 8'h10, "R4");
    ticks(7);

    // R5 wrap; R4 no restart when disabled
    reset_dut(10'h000, 16'h8000);
    go();
    ticks(65534);
    exp_in(1, S_CNT, 16'hFFFF, "R5"); exp_in(1, S_ST, 8'h10, "R4");
    exp_in(2, S_CNT, 0, "R5"); exp_in(2, S_ST, 8'h11, "R5");
    ticks(2);

    // R6 capture A on rising, B on falling
    reset_dut(10'h009, 16'h8000);
    go();
    ticks(10);
    pin_a = 1;
    exp_in(2, S_A, 0, "R6"); exp_in(3, S_A, capv(2), "R6");
    ticks(4);
    pin_a = 0;
    exp_in(3, S_B, capv(2), "R6"); exp_in(3, S_ST, 8'h60, "R9");
    ticks(3);

    // R7 ordering: A on falling, B on rising, pin rises first
    reset_dut(10'h006, 16'h8000);
    go();
    ticks(3);
    pin_a = 1;
    exp_in(4, S_B, 0, "R7"); exp_in(4, S_A, 0, "R7"); exp_in(4, S_ST, 0, "R7");
    ticks(5);
    pin_a = 0;
    exp_in(3, S_A, capv(2), "R7");
    ticks(4);
    pin_a = 1;
    exp_in(3, S_B, capv(2), "R7");
    ticks(4);
    // R7: A on both, B never, second edge must not reload A
    reset_dut(10'h003, 16'h8000);
    go();
    ticks(2);
    pin_a = 1;
    v = capv(2);
    exp_in(3, S_A, v, "R7");
    ticks(4);
    pin_a = 0;
    exp_in(4, S_A, v, "R7"); exp_in(4, S_B, 0, "R7"); exp_in(4, S_ST, 8'h20, "R7");
    ticks(4);

    // R8 overrun, then acknowledged load without overrun; R9 clear
    reset_dut(10'h009, 16'h8000);
    go();
    ticks(2); pin_a = 1;
    ticks(4); pin_a = 0;
    ticks(4); pin_a = 1;
    exp_in(3, S_ST, 8'h62, "R8");
    ticks(4);
    rd_status = 1; rd_a = 1; rd_b = 1;
    ticks(1);
    rd_status = 0; rd_a = 0; rd_b = 0;
    pin_a = 0;
    exp_in(1, S_ST, 8'h00, "R9"); exp_in(3, S_ST, 8'h40, "R8");
    ticks(4);

    // R10 external trigger on rising pin B
    reset_dut(10'h050, 16'h8000);
    go();
    ticks(20);
    pin_b = 1;
    exp_in(2, S_CNT, capv(2), "R10"); exp_in(3, S_CNT, 0, "R10");
    exp_in(3, S_ST, 8'h80, "R10"); exp_in(5, S_CNT, 2, "R10");
    ticks(3);
    pcyc = cyc;
    ticks(4);
    pin_b = 0; pin_a = 1;
    exp_in(5, S_CNT, capv(5), "R10");
    ticks(5);

    // R11 stop on B load
    reset_dut(10'h109, 16'h8000);
    go();
    ticks(2); pin_a = 1;
    ticks(4); pin_a = 0;
    v = capv(2);
    exp_in(3, S_B, v, "R11"); exp_in(3, S_CNT, v, "R11");
    exp_in(6, S_CNT, v, "R11"); exp_in(6, S_ON, 1, "R11");
    ticks(6);
    cmd_swtrig = 1; ticks(1); cmd_swtrig = 0;
    exp_in(3, S_CNT, 3, "R11");
    ticks(3);
    // R11 disable on B load
    reset_dut(10'h209, 16'h8000);
    go();
    ticks(2); pin_a = 1;
    ticks(4); pin_a = 0;
    v = capv(2);
    exp_in(3, S_CNT, v, "R11"); exp_in(6, S_CNT, v, "R11"); exp_in(6, S_ON, 0, "R11");
    ticks(6);

    // R12 interrupt mask
    reset_dut(10'h001, 16'h8000);
    go();
    irq_set = 8'h20; ticks(1); irq_set = 0;
    exp_in(1, S_MSK, 8'h20, "R12"); exp_in(1, S_IRQ, 0, "R12");
    ticks(1);
    pin_a = 1;
    exp_in(2, S_IRQ, 0, "R12"); exp_in(3, S_IRQ, 1, "R12");
    ticks(3);
    irq_clr = 8'h20; irq_set = 8'h20; ticks(1); irq_clr = 0; irq_set = 0;
    exp_in(1, S_IRQ, 0, "R12"); exp_in(1, S_MSK, 0, "R12"); exp_in(1, S_ST, 8'h20, "R12");
    ticks(3);

    if (sbq.size() != 0) begin
      n_bad += sbq.size();
      $display("FAIL scoreboard: actual %0d items left expected 0", sbq.size());
    end
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule